// File: doc/BRIEF.md
# Doorbell Message Send and Clear Unit

This block handles inter-core doorbell messages for a small cluster of cores. A send command carries an operand word. A type field in that operand picks either a normal doorbell or a critical doorbell. A broadcast flag or an identifier tag then picks the receiving cores. Each receiving core gets the chosen pending bit set, together with a one-cycle interrupt request strobe.

A clear command also carries an operand and names the core that issues it. It removes the selected kind of pending bit from that one core only. Any type code other than the two doorbell kinds is dropped without effect, and this includes the guest message codes.

The operand fields sit at fixed positions:

- Bits [31:27] hold the type code: 0 is a normal doorbell and 1 is a critical doorbell.
- Bit 26 is the broadcast flag.
- Bits [13:0] hold the target identifier tag.

Each core presents its own 14-bit identifier on `core_pir`. Core i owns bits [14*i+13 : 14*i].

Top module: `db_msg_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every pending bit and every interrupt strobe is 0.
- R2: A send with type code 0 sets `pend_db[i]` one clock after the command, for every core i whose identifier equals operand bits [13:0].
- R3: A send with type code 1 sets `pend_crit[i]` one clock after the command, for every core i whose identifier matches the tag.
- R4: A send or clear whose type code (bits [31:27]) is neither 0 nor 1 changes no pending bit and raises no strobe.
- R5: A valid send with bit 26 set reaches all cores, whatever the tag holds.
- R6: A valid send without broadcast leaves untouched every core whose identifier differs from the tag.
- R7: A clear with type 0 or 1 clears only that kind of pending bit, and only on the core named by `clr_core`. The tag and broadcast fields of the clear operand are ignored.
- R8: When a send and a clear act on the same bit of the same core in the same cycle, the bit ends set.
- R9: Each valid send raises `irq_req[i]` for exactly one cycle on every core it reaches. This holds even if that core's bit was already pending.
- R10: With no command acting on a pending bit, the bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_req | input | 1 | Send command valid this cycle |
| snd_opnd | input | 32 | Send operand word |
| clr_req | input | 1 | Clear command valid this cycle |
| clr_core | input | CIDX_W (2) | Index of the core issuing the clear |
| clr_opnd | input | 32 | Clear operand word |
| core_pir | input | N_CORES*14 (56) | Identifier of each core, core i at [14*i+13:14*i] |
| pend_db | output | N_CORES (4) | Normal doorbell pending, one bit per core |
| pend_crit | output | N_CORES (4) | Critical doorbell pending, one bit per core |
| irq_req | output | N_CORES (4) | One-cycle interrupt request strobe per core |

## Verification
Every result of this block comes from a single register stage. A command presented before a rising edge shows up on the pending outputs and on the strobes right after that edge. The strobe falls again one edge later unless another send reaches the same core.

The bench drives each stimulus row at a falling edge and samples all three outputs at the next falling edge. It then drives the following row in the same half cycle. This lets back-to-back sends, and the idle cycle after a send, each be checked against the one cycle in which their result is due.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int OPND_W    = 32;
  localparam int TYPE_HI   = 31;
  localparam int TYPE_LO   = 27;
  localparam int TYPE_W    = TYPE_HI - TYPE_LO + 1;
  localparam int BCAST_POS = 26;
  localparam int TAG_W     = 14;

  localparam logic [TYPE_W-1:0] KIND_NORM = 5'd0;
  localparam logic [TYPE_W-1:0] KIND_CRIT = 5'd1;

  typedef struct packed {
    logic ok;    // type code is one of the two doorbell kinds
    logic crit;  // critical kind when ok
  } db_kind_t;

  function automatic db_kind_t db_kind(input logic [TYPE_W-1:0] code);
    db_kind_t k;
    k.ok   = 1'b0;
    k.crit = 1'b0;
    if (code == KIND_NORM) begin
      k.ok = 1'b1;
    end else if (code == KIND_CRIT) begin
      k.ok   = 1'b1;
      k.crit = 1'b1;
    end
    return k;
  endfunction

  function automatic logic db_reaches(input logic bcast,
                                      input logic [TAG_W-1:0] tag,
                                      input logic [TAG_W-1:0] pir);
    return bcast || (tag == pir);
  endfunction
endpackage

// File: rtl/db_opnd_decode.sv
module db_opnd_decode
  import db_pkg::*;
(
  input  logic              req_i,
  input  logic [OPND_W-1:0] opnd_i,
  output logic              ok_o,
  output logic              crit_o,
  output logic              bcast_o,
  output logic [TAG_W-1:0]  tag_o
);
  db_kind_t kind;
  logic     unused_bits;

  assign kind        = db_kind(opnd_i[TYPE_HI:TYPE_LO]);
  assign ok_o        = req_i && kind.ok;
  assign crit_o      = kind.crit;
  assign bcast_o     = opnd_i[BCAST_POS];
  assign tag_o       = opnd_i[TAG_W-1:0];
  assign unused_bits = ^opnd_i[BCAST_POS-1:TAG_W];
endmodule

// File: rtl/db_core_slot.sv
module db_core_slot
  import db_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] pir_i,
  input  logic             snd_ok_i,
  input  logic             snd_crit_i,
  input  logic             snd_bcast_i,
  input  logic [TAG_W-1:0] snd_tag_i,
  input  logic             clr_ok_i,
  input  logic             clr_crit_i,
  output logic             pend_db_o,
  output logic             pend_crit_o,
  output logic             irq_o
);
  // named events of this core, brought out for the checks below
  logic hit;
  logic set_db, set_crit;
  logic drop_db, drop_crit;
  logic pend_db_q, pend_crit_q, irq_q;

  assign hit       = snd_ok_i && db_reaches(snd_bcast_i, snd_tag_i, pir_i);
  assign set_db    = hit && !snd_crit_i;
  assign set_crit  = hit &&  snd_crit_i;
  assign drop_db   = clr_ok_i && !clr_crit_i;
  assign drop_crit = clr_ok_i &&  clr_crit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_db_q   <= 1'b0;
      pend_crit_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      // a set in the same cycle overrides a clear
      pend_db_q   <= set_db   | (pend_db_q   & ~drop_db);
      pend_crit_q <= set_crit | (pend_crit_q & ~drop_crit);
      irq_q       <= hit;
    end
  end

  assign pend_db_o   = pend_db_q;
  assign pend_crit_o = pend_crit_q;
  assign irq_o       = irq_q;

  p_set_db_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_db |=> pend_db_o);
  p_set_crit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_crit |=> pend_crit_o);
  p_drop_db_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_db && !set_db) |=> !pend_db_o);
  p_drop_crit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_crit && !set_crit) |=> !pend_crit_o);
  p_win_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_db && drop_db) |=> pend_db_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_db && !drop_db && !set_crit && !drop_crit) |=> ($stable(pend_db_o) && $stable(pend_crit_o)));
  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_o);
  p_strobe_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !irq_o);
endmodule

// File: rtl/db_msg_unit.sv
module db_msg_unit
  import db_pkg::*;
#(
  parameter  int N_CORES = 4,
  localparam int CIDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snd_req,
  input  logic [OPND_W-1:0]        snd_opnd,
  input  logic                     clr_req,
  input  logic [CIDX_W-1:0]        clr_core,
  input  logic [OPND_W-1:0]        clr_opnd,
  input  logic [N_CORES*TAG_W-1:0] core_pir,
  output logic [N_CORES-1:0]       pend_db,
  output logic [N_CORES-1:0]       pend_crit,
  output logic [N_CORES-1:0]       irq_req
);
  logic             snd_ok, snd_crit, snd_bcast;
  logic [TAG_W-1:0] snd_tag;
  logic             clr_ok, clr_crit, unused_clr_bcast;
  logic [TAG_W-1:0] unused_clr_tag;

  db_opnd_decode u_snd_dec (
    .req_i  (snd_req),
    .opnd_i (snd_opnd),
    .ok_o   (snd_ok),
    .crit_o (snd_crit),
    .bcast_o(snd_bcast),
    .tag_o  (snd_tag)
  );

  // the clear acts on the issuing core only: tag and broadcast unused
  db_opnd_decode u_clr_dec (
    .req_i  (clr_req),
    .opnd_i (clr_opnd),
    .ok_o   (clr_ok),
    .crit_o (clr_crit),
    .bcast_o(unused_clr_bcast),
    .tag_o  (unused_clr_tag)
  );

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_core
    logic clr_here;
    assign clr_here = clr_ok && (clr_core == CIDX_W'(gi));

    db_core_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .pir_i      (core_pir[gi*TAG_W +: TAG_W]),
      .snd_ok_i   (snd_ok),
      .snd_crit_i (snd_crit),
      .snd_bcast_i(snd_bcast),
      .snd_tag_i  (snd_tag),
      .clr_ok_i   (clr_here),
      .clr_crit_i (clr_crit),
      .pend_db_o  (pend_db[gi]),
      .pend_crit_o(pend_crit[gi]),
      .irq_o      (irq_req[gi])
    );
  end

  p_bad_send_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_req && !snd_ok) |=> (irq_req == '0));
  p_bad_clear_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !clr_ok && !snd_ok) |=> ($stable(pend_db) && $stable(pend_crit)));
  p_bcast_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_ok && snd_bcast) |=> (&irq_req));
  p_strobe_needs_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_ok |=> (irq_req == '0));
  p_reset_clean_r1: assert property (@(posedge clk)
    !rst_n |=> (pend_db == '0 && pend_crit == '0 && irq_req == '0));
endmodule

// File: tb/tb_db_msg_unit.sv
module tb_db_msg_unit;
  localparam int NC = 4;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          snd_req, clr_req;
  logic [31:0]   snd_opnd, clr_opnd;
  logic [1:0]    clr_core;
  logic [NC*14-1:0] core_pir;
  logic [NC-1:0] pend_db, pend_crit, irq_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  db_msg_unit #(.N_CORES(NC)) dut (
    .clk(clk), .rst_n(rst_n),
    .snd_req(snd_req), .snd_opnd(snd_opnd),
    .clr_req(clr_req), .clr_core(clr_core), .clr_opnd(clr_opnd),
    .core_pir(core_pir),
    .pend_db(pend_db), .pend_crit(pend_crit), .irq_req(irq_req)
  );

  typedef struct packed {
    logic        s_req;
    logic [31:0] s_op;
    logic        c_req;
    logic [1:0]  c_core;
    logic [31:0] c_op;
    logic [3:0]  e_db;
    logic [3:0]  e_crit;
    logic [3:0]  e_irq;
    logic [3:0]  rq;
  } vec_t;

  // identifiers: core0=5, core1=9, core2=5, core3=0x3FFF
  // type code is op[31:27] (0 normal, 1 critical), broadcast op[26], tag op[13:0]
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 32'h0000_0005, 1'b0, 2'd0, 32'h0,         4'b0101, 4'b0000, 4'b0101, 4'd2},  // R2
    '{1'b1, 32'h0800_0009, 1'b0, 2'd0, 32'h0,         4'b0101, 4'b0010, 4'b0010, 4'd3},  // R3
    '{1'b1, 32'h1400_0000, 1'b0, 2'd0, 32'h0,         4'b0101, 4'b0010, 4'b0000, 4'd4},  // R4 guest bcast
    '{1'b1, 32'h0400_0007, 1'b0, 2'd0, 32'h0,         4'b1111, 4'b0010, 4'b1111, 4'd5},  // R5
    '{1'b0, 32'h0,         1'b1, 2'd1, 32'h0000_0000, 4'b1101, 4'b0010, 4'b0000, 4'd7},  // R7
    '{1'b0, 32'h0,         1'b1, 2'd1, 32'h0800_0000, 4'b1101, 4'b0000, 4'b0000, 4'd7},  // R7
    '{1'b1, 32'h0800_3FFF, 1'b0, 2'd0, 32'h0,         4'b1101, 4'b1000, 4'b1000, 4'd6},  // R6
    '{1'b1, 32'h0000_0005, 1'b1, 2'd0, 32'h0000_0000, 4'b1101, 4'b1000, 4'b0101, 4'd8},  // R8
    '{1'b0, 32'h0,         1'b1, 2'd2, 32'h2000_0000, 4'b1101, 4'b1000, 4'b0000, 4'd4},  // R4 clear
    '{1'b1, 32'h0000_1234, 1'b0, 2'd0, 32'h0,         4'b1101, 4'b1000, 4'b0000, 4'd6},  // R6
    '{1'b0, 32'h0,         1'b0, 2'd0, 32'h0,         4'b1101, 4'b1000, 4'b0000, 4'd10}, // R10
    '{1'b0, 32'h0,         1'b1, 2'd3, 32'h0000_1234, 4'b0101, 4'b1000, 4'b0000, 4'd7},  // R7
    '{1'b1, 32'h0C00_0000, 1'b1, 2'd3, 32'h0800_0000, 4'b0101, 4'b1111, 4'b1111, 4'd8},  // R8
    '{1'b0, 32'h0,         1'b1, 2'd2, 32'hF800_0000, 4'b0101, 4'b1111, 4'b0000, 4'd4},  // R4
    '{1'b1, 32'h0000_0005, 1'b0, 2'd0, 32'h0,         4'b0101, 4'b1111, 4'b0101, 4'd9},  // R9
    '{1'b0, 32'h0,         1'b0, 2'd0, 32'h0,         4'b0101, 4'b1111, 4'b0000, 4'd9}   // R9
  };

  task automatic chk(input string what, input int rq, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    snd_req  = v.s_req;
    snd_opnd = v.s_op;
    clr_req  = v.c_req;
    clr_core = v.c_core;
    clr_opnd = v.c_op;
  endtask

  task automatic idle();
    snd_req = 1'b0; snd_opnd = '0; clr_req = 1'b0; clr_core = '0; clr_opnd = '0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    core_pir = {14'h3FFF, 14'd5, 14'd9, 14'd5};
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("reset db", 1, pend_db, 4'b0000);
    chk("reset crit", 1, pend_crit, 4'b0000);
    chk("reset irq", 1, irq_req, 4'b0000);
    rst_n = 1'b1;

    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk("pend_db", int'(VEC[i].rq), pend_db, VEC[i].e_db);
      chk("pend_crit", int'(VEC[i].rq), pend_crit, VEC[i].e_crit);
      chk("irq_req", int'(VEC[i].rq), irq_req, VEC[i].e_irq);
      if (i + 1 < NV) drive(VEC[i + 1]);
      else idle();
    end

    // R9: two back-to-back sends to core1 give one strobe each, then quiet
    snd_req = 1'b1; snd_opnd = 32'h0000_0009;
    @(negedge clk);
    chk("strobe first send", 9, irq_req, 4'b0010);
    @(negedge clk);
    chk("strobe second send", 9, irq_req, 4'b0010);
    idle();
    @(negedge clk);
    chk("strobe ends", 9, irq_req, 4'b0000);
    chk("db after sends", 2, pend_db, 4'b0111);

    // R1: reset in mid-run wipes pending state
    rst_n = 1'b0;
    @(negedge clk);
    chk("mid reset db", 1, pend_db, 4'b0000);
    chk("mid reset crit", 1, pend_crit, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("after reset irq", 1, irq_req, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule